// File: doc/BRIEF.md
# Disk Controller Recording-Mode and Configuration-Lock Registers

This block holds the recording-mode state and the protected FIFO configuration of a floppy-style disk controller. A command port writes three things: a mode byte (a global two-bit recording code, a per-drive auto-perpendicular mask and an overwrite-enable flag), a configure word (FIFO disable, FIFO threshold, precompensation start track) and a lock command. Each cycle the block resolves, for the drive currently selected, whether that drive records perpendicularly, how many Gap2 bytes the write path must emit, the Gap2 format length, and the write precompensation to use.

There are two reset inputs and they act differently. A software reset clears only the global recording code, and clears the configure fields only while they are unlocked. A hardware reset clears everything, including the per-drive mask and the lock. The lock command returns a status byte on the following cycle.

Top module: `dskc_modelock`

## Requirements
- R1: The global code is {cmd_data[5], cmd_data[4]} of a mode command (op 0). Code 00 and 01 give conventional recording with 0 Gap2 bytes written. Code 10 gives perpendicular recording with 19 bytes. Code 11 gives perpendicular recording with 38 bytes.
- R2: gap2_len is 41 when the global code is 11, and 22 for every other code, including drives made perpendicular through the mask.
- R3: When the global code is 00, a drive whose mask bit (cmd_data[3:0], bit n for drive n) is 1 is perpendicular, with 19 Gap2 bytes at rate 00, 38 at rate 11 and 0 at rates 01 and 10. When the global code is not 00, the mask has no effect.
- R4: A mode command updates the drive mask only when cmd_data[7] is 1. Otherwise the mask keeps its previous value.
- R5: precomp_out is 0 for a perpendicular drive and equals precomp_prog for a conventional drive.
- R6: A software reset clears the global code to 00 and leaves the drive mask unchanged.
- R7: A hardware reset clears the code, the mask and the lock, and sets fifo_off=1, fifo_level=0 and precomp_track=0.
- R8: A software reset with the lock clear restores fifo_off=1, fifo_level=0 and precomp_track=0. With the lock set, it leaves all three unchanged.
- R9: A configure command (op 1) loads precomp_track from cmd_data[15:8], fifo_off from cmd_data[6] and fifo_level from cmd_data[3:0].
- R10: A lock command (op 2) sets the lock to cmd_data[0]. In the next cycle stat_valid is 1 for one cycle and stat_byte carries the new lock value in bit 4, with all other bits 0.
- R11: A hardware reset overrides a software reset in the same cycle. A software reset overrides a command in the same cycle, and that command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 mode, 1 configure, 2 lock, 3 none |
| cmd_data | input | 16 | Command payload |
| drv_sel | input | 2 | Currently selected drive |
| rate_sel | input | 2 | Programmed data rate (00 = 500 Kbps, 11 = 1 Mbps) |
| precomp_prog | input | 3 | Programmed write precompensation code |
| perp_mode | output | 1 | Selected drive records perpendicularly |
| gap2_wr | output | 6 | Gap2 bytes written by a write-data operation |
| gap2_len | output | 6 | Gap2 format length in bytes |
| precomp_out | output | 3 | Precompensation applied to the selected drive |
| fifo_off | output | 1 | FIFO disable setting |
| fifo_level | output | 4 | FIFO threshold |
| precomp_track | output | 8 | Precompensation start track |
| lock_q | output | 1 | Configuration lock |
| stat_valid | output | 1 | Lock status byte valid |
| stat_byte | output | 8 | Lock status byte |

## Verification
The bench covers the code-01 case, which a careless decode would treat as perpendicular and which would then emit 19 bytes. It writes a mode byte with the overwrite flag clear and then checks that the mask survives; a design that always loads the mask would lose the auto-perpendicular drives. It runs a software reset with the lock both set and clear; a design that ignores the lock would wipe the configuration, and one that keeps too much would leave the global code standing. It also drives the resets together with a command and with each other, where a wrong priority shows up as a code that was not cleared or as a lock that survives a hardware reset.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  localparam int CMD_W = 16;

  typedef enum logic [1:0] {
    OP_MODE = 2'd0,
    OP_CFG  = 2'd1,
    OP_LOCK = 2'd2,
    OP_NONE = 2'd3
  } cmd_op_e;

  // Gap2 format length from the global recording code.
  function automatic logic [5:0] gap2_fmt_len(input logic [1:0] code);
    return (code == 2'b11) ? 6'd41 : 6'd22;
  endfunction

  // Gap2 bytes written when the global code selects the mode.
  function automatic logic [5:0] gap2_by_code(input logic [1:0] code);
    case (code)
      2'b10:   return 6'd19;
      2'b11:   return 6'd38;
      default: return 6'd0;
    endcase
  endfunction

  // Gap2 bytes written for a mask-selected drive, from the data rate.
  function automatic logic [5:0] gap2_by_rate(input logic [1:0] rate);
    case (rate)
      2'b00:   return 6'd19;
      2'b11:   return 6'd38;
      default: return 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/dskc_mode_regs.sv
module dskc_mode_regs #(
  parameter int DRV_N = 4
) (
  input  logic             clk,
  input  logic             hw_rst,
  input  logic             sw_rst,
  input  logic             wr_en,
  input  logic             ow_en,
  input  logic [1:0]       code_in,
  input  logic [DRV_N-1:0] mask_in,
  output logic [1:0]       code_q,
  output logic [DRV_N-1:0] mask_q
);
  logic mask_load;
  assign mask_load = wr_en && ow_en;

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      code_q <= 2'b00;
      mask_q <= '0;
    end else if (sw_rst) begin
      code_q <= 2'b00;
    end else if (wr_en) begin
      code_q <= code_in;
      if (mask_load) mask_q <= mask_in;
    end
  end

  assert_swrst_code_R6: assert property (@(posedge clk) disable iff (hw_rst)
    sw_rst |=> code_q == 2'b00);
  assert_swrst_mask_R6: assert property (@(posedge clk) disable iff (hw_rst)
    sw_rst |=> mask_q == $past(mask_q));
  assert_no_ow_mask_R4: assert property (@(posedge clk) disable iff (hw_rst)
    (wr_en && !ow_en) |=> mask_q == $past(mask_q));
  assert_hw_clear_R7: assert property (@(posedge clk)
    hw_rst |=> (code_q == 2'b00 && mask_q == '0));
endmodule

// File: rtl/dskc_cfg_lock.sv
module dskc_cfg_lock #(
  parameter int LVL_W = 4,
  parameter int TRK_W = 8
) (
  input  logic             clk,
  input  logic             hw_rst,
  input  logic             sw_rst,
  input  logic             cfg_we,
  input  logic             lock_we,
  input  logic             lock_in,
  input  logic             off_in,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic [TRK_W-1:0] trk_in,
  output logic             fifo_off,
  output logic [LVL_W-1:0] fifo_level,
  output logic [TRK_W-1:0] precomp_track,
  output logic             lock_q,
  output logic             stat_valid,
  output logic [7:0]       stat_byte
);
  localparam int STAT_LOCK_BIT = 4;

  logic restore_dflt;
  assign restore_dflt = hw_rst || (sw_rst && !lock_q);

  always_ff @(posedge clk) begin
    if (restore_dflt) begin
      fifo_off      <= 1'b1;
      fifo_level    <= '0;
      precomp_track <= '0;
    end else if (!sw_rst && cfg_we) begin
      fifo_off      <= off_in;
      fifo_level    <= lvl_in;
      precomp_track <= trk_in;
    end
  end

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      lock_q     <= 1'b0;
      stat_valid <= 1'b0;
      stat_byte  <= 8'h00;
    end else begin
      stat_valid <= lock_we && !sw_rst;
      if (lock_we && !sw_rst) begin
        lock_q                   <= lock_in;
        stat_byte                <= 8'h00;
        stat_byte[STAT_LOCK_BIT] <= lock_in;
      end
    end
  end

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && lock_q) |=> ({fifo_off, fifo_level, precomp_track} ==
                            $past({fifo_off, fifo_level, precomp_track})));
  assert_unlocked_dflt_R8: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && !lock_q) |=> (fifo_off && fifo_level == '0 && precomp_track == '0));
  assert_stat_follows_R10: assert property (@(posedge clk) disable iff (hw_rst)
    (lock_we && !sw_rst) |=> (stat_valid && stat_byte[STAT_LOCK_BIT] == $past(lock_in)
                              && lock_q == $past(lock_in)));
  assert_hw_unlock_R7: assert property (@(posedge clk)
    hw_rst |=> (!lock_q && fifo_off && !stat_valid));
endmodule

// File: rtl/dskc_drive_resolve.sv
module dskc_drive_resolve
  import dskc_pkg::*;
#(
  parameter int DRV_N = 4,
  parameter int DRV_W = 2,
  parameter int PC_W  = 3
) (
  input  logic             clk,
  input  logic             hw_rst,
  input  logic [1:0]       code_q,
  input  logic [DRV_N-1:0] mask_q,
  input  logic [DRV_W-1:0] drv_sel,
  input  logic [1:0]       rate_sel,
  input  logic [PC_W-1:0]  precomp_prog,
  output logic             perp_mode,
  output logic [5:0]       gap2_wr,
  output logic [5:0]       gap2_len,
  output logic [PC_W-1:0]  precomp_out
);
  // Internal events named for the checks.
  logic global_perp;
  logic auto_perp;

  assign global_perp = code_q[1];
  assign auto_perp   = (code_q == 2'b00) && mask_q[drv_sel];

  always_comb begin
    perp_mode   = global_perp || auto_perp;
    gap2_len    = gap2_fmt_len(code_q);
    gap2_wr     = auto_perp ? gap2_by_rate(rate_sel) : gap2_by_code(code_q);
    precomp_out = perp_mode ? '0 : precomp_prog;
  end

  assert_conv_no_gap_R1: assert property (@(posedge clk) disable iff (hw_rst)
    !perp_mode |-> gap2_wr == 6'd0);
  assert_long_fmt_R2: assert property (@(posedge clk) disable iff (hw_rst)
    gap2_len == 6'd41 |-> (gap2_wr == 6'd38 && perp_mode));
  assert_mask_only_code0_R3: assert property (@(posedge clk) disable iff (hw_rst)
    (code_q != 2'b00) |-> perp_mode == code_q[1]);
  assert_perp_precomp_R5: assert property (@(posedge clk) disable iff (hw_rst)
    (perp_mode && precomp_prog != '0) |-> precomp_out != precomp_prog);
endmodule

// File: rtl/dskc_modelock.sv
module dskc_modelock
  import dskc_pkg::*;
#(
  parameter int DRV_N = 4,
  parameter int PC_W  = 3,
  parameter int LVL_W = 4,
  parameter int TRK_W = 8
) (
  input  logic                     clk,
  input  logic                     hw_rst,
  input  logic                     sw_rst,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [CMD_W-1:0]         cmd_data,
  input  logic [$clog2(DRV_N)-1:0] drv_sel,
  input  logic [1:0]               rate_sel,
  input  logic [PC_W-1:0]          precomp_prog,
  output logic                     perp_mode,
  output logic [5:0]               gap2_wr,
  output logic [5:0]               gap2_len,
  output logic [PC_W-1:0]          precomp_out,
  output logic                     fifo_off,
  output logic [LVL_W-1:0]         fifo_level,
  output logic [TRK_W-1:0]         precomp_track,
  output logic                     lock_q,
  output logic                     stat_valid,
  output logic [7:0]               stat_byte
);
  localparam int DRV_W = $clog2(DRV_N);

  logic             mode_we, cfg_we, lock_we;
  logic [1:0]       code_q;
  logic [DRV_N-1:0] mask_q;

  assign mode_we = cmd_valid && (cmd_op == OP_MODE);
  assign cfg_we  = cmd_valid && (cmd_op == OP_CFG);
  assign lock_we = cmd_valid && (cmd_op == OP_LOCK);

  dskc_mode_regs #(.DRV_N(DRV_N)) u_mode (
    .clk     (clk),
    .hw_rst  (hw_rst),
    .sw_rst  (sw_rst),
    .wr_en   (mode_we),
    .ow_en   (cmd_data[7]),
    .code_in (cmd_data[5:4]),
    .mask_in (cmd_data[DRV_N-1:0]),
    .code_q  (code_q),
    .mask_q  (mask_q)
  );

  dskc_cfg_lock #(.LVL_W(LVL_W), .TRK_W(TRK_W)) u_cfg (
    .clk           (clk),
    .hw_rst        (hw_rst),
    .sw_rst        (sw_rst),
    .cfg_we        (cfg_we),
    .lock_we       (lock_we),
    .lock_in       (cmd_data[0]),
    .off_in        (cmd_data[6]),
    .lvl_in        (cmd_data[LVL_W-1:0]),
    .trk_in        (cmd_data[8 +: TRK_W]),
    .fifo_off      (fifo_off),
    .fifo_level    (fifo_level),
    .precomp_track (precomp_track),
    .lock_q        (lock_q),
    .stat_valid    (stat_valid),
    .stat_byte     (stat_byte)
  );

  dskc_drive_resolve #(.DRV_N(DRV_N), .DRV_W(DRV_W), .PC_W(PC_W)) u_res (
    .clk          (clk),
    .hw_rst       (hw_rst),
    .code_q       (code_q),
    .mask_q       (mask_q),
    .drv_sel      (drv_sel),
    .rate_sel     (rate_sel),
    .precomp_prog (precomp_prog),
    .perp_mode    (perp_mode),
    .gap2_wr      (gap2_wr),
    .gap2_len     (gap2_len),
    .precomp_out  (precomp_out)
  );

  assert_sw_drops_cmd_R11: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && cmd_valid) |=> (code_q == 2'b00 && !stat_valid));
endmodule

// File: tb/dskc_modelock_bench.sv
module dskc_modelock_bench;
  logic clk = 1'b0;
  logic hw_rst = 1'b1, sw_rst = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic [15:0] cmd_data = '0;
  logic [1:0] drv_sel = '0, rate_sel = '0;
  logic [2:0] precomp_prog = 3'd5;
  logic perp_mode, fifo_off, lock_q, stat_valid;
  logic [5:0] gap2_wr, gap2_len;
  logic [2:0] precomp_out;
  logic [3:0] fifo_level;
  logic [7:0] precomp_track, stat_byte;

  always #2.5 clk = ~clk;

  dskc_modelock u_dskc_modelock (.*);

  typedef struct {
    string      tag;
    logic [38:0] val;
  } exp_t;

  exp_t q[$];
  event ev_chk;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model of the registers, kept from the requirements.
  logic       m_wg = 0, m_gp = 0, m_lock = 0, m_off = 1, m_sv = 0;
  logic [3:0] m_mask = 0, m_lvl = 0;
  logic [7:0] m_trk = 0;

  function automatic logic [38:0] predict(logic [1:0] d, logic [1:0] r, logic [2:0] pc);
    logic auto, p;
    logic [5:0] wr, ln;
    auto = !m_wg && !m_gp && m_mask[d];
    p    = auto || m_wg;
    if (auto)      wr = (r == 2'b00) ? 6'd19 : ((r == 2'b11) ? 6'd38 : 6'd0);
    else if (m_wg) wr = m_gp ? 6'd38 : 6'd19;
    else           wr = 6'd0;
    ln = (m_wg && m_gp) ? 6'd41 : 6'd22;
    return {p, wr, ln, (p ? 3'd0 : pc), m_off, m_lvl, m_trk, m_lock,
            m_sv, (m_sv ? {3'b000, m_lock, 4'b0000} : stat_byte)};
  endfunction

  // Monitor: pops expected items and compares to the outputs.
  initial begin
    forever begin
      @(ev_chk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [38:0] act;
        e = q.pop_front();
        act = {perp_mode, gap2_wr, gap2_len, precomp_out, fifo_off, fifo_level,
               precomp_track, lock_q, stat_valid, stat_byte};
        n_chk++;
        if (act !== e.val) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
        end
      end
    end
  end

  task automatic chk(string tag, logic [1:0] d, logic [1:0] r, logic [2:0] pc);
    drv_sel = d; rate_sel = r; precomp_prog = pc;
    q.push_back('{tag, predict(d, r, pc)});
    -> ev_chk;
    #2;
  endtask

  task automatic model_cmd(logic [1:0] op, logic [15:0] dat);
    m_sv = 0;
    case (op)
      2'd0: begin
        {m_wg, m_gp} = dat[5:4];
        if (dat[7]) m_mask = dat[3:0];
      end
      2'd1: begin m_trk = dat[15:8]; m_off = dat[6]; m_lvl = dat[3:0]; end
      2'd2: begin m_lock = dat[0]; m_sv = 1; end
      default: ;
    endcase
  endtask

  task automatic model_sw();
    m_wg = 0; m_gp = 0; m_sv = 0;
    if (!m_lock) begin m_off = 1; m_lvl = 0; m_trk = 0; end
  endtask

  task automatic model_hw();
    m_wg = 0; m_gp = 0; m_mask = 0; m_lock = 0; m_sv = 0;
    m_off = 1; m_lvl = 0; m_trk = 0;
  endtask

  task automatic cmd(logic [1:0] op, logic [15:0] dat);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = dat;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 2'd3;
    model_cmd(op, dat);
  endtask

  task automatic pulse(logic hw, logic sw, logic with_cmd, logic [1:0] op, logic [15:0] dat);
    @(negedge clk);
    hw_rst = hw; sw_rst = sw;
    cmd_valid = with_cmd; cmd_op = op; cmd_data = dat;
    @(negedge clk);
    hw_rst = 0; sw_rst = 0; cmd_valid = 0; cmd_op = 2'd3;
    if (hw) model_hw(); else if (sw) model_sw(); else m_sv = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hw_rst = 0; model_hw();
    chk("R7 reset state", 2'd0, 2'd0, 3'd5);

    cmd(2'd0, 16'h0020);
    chk("R1 code 10 perpendicular 19", 2'd1, 2'd0, 3'd5);
    chk("R5 perpendicular precomp zero", 2'd3, 2'd1, 3'd6);
    cmd(2'd0, 16'h0030);
    chk("R2 code 11 length 41", 2'd0, 2'd0, 3'd4);
    cmd(2'd0, 16'h0010);
    chk("R1 code 01 conventional", 2'd2, 2'd3, 3'd3);

    cmd(2'd0, 16'h0085);
    chk("R3 masked drive rate 00", 2'd0, 2'd0, 3'd5);
    chk("R3 masked drive rate 11", 2'd2, 2'd3, 3'd5);
    chk("R3 masked drive rate 01", 2'd0, 2'd1, 3'd5);
    chk("R5 unmasked drive keeps precomp", 2'd1, 2'd3, 3'd7);

    cmd(2'd0, 16'h000A);
    chk("R4 mask kept without overwrite", 2'd0, 2'd3, 3'd5);
    chk("R4 unselected bit not loaded", 2'd1, 2'd3, 3'd5);

    cmd(2'd0, 16'h0010);
    chk("R3 mask ignored under code 01", 2'd0, 2'd0, 3'd5);
    cmd(2'd0, 16'h0020);
    pulse(1'b0, 1'b1, 1'b0, 2'd3, 16'h0000);
    chk("R6 software reset keeps mask", 2'd2, 2'd0, 3'd5);
    chk("R6 software reset clears code", 2'd1, 2'd0, 3'd5);

    cmd(2'd1, 16'h5A47);
    chk("R9 configure fields", 2'd1, 2'd0, 3'd5);
    pulse(1'b0, 1'b1, 1'b0, 2'd3, 16'h0000);
    chk("R8 unlocked software reset defaults", 2'd1, 2'd0, 3'd5);

    cmd(2'd1, 16'h3C0B);
    cmd(2'd2, 16'h0001);
    chk("R10 lock status set", 2'd1, 2'd0, 3'd5);
    pulse(1'b0, 1'b1, 1'b0, 2'd3, 16'h0000);
    chk("R8 locked software reset holds", 2'd1, 2'd0, 3'd5);
    cmd(2'd2, 16'h0000);
    chk("R10 lock status clear", 2'd1, 2'd0, 3'd5);

    cmd(2'd2, 16'h0001);
    cmd(2'd1, 16'hA448);
    pulse(1'b1, 1'b0, 1'b0, 2'd3, 16'h0000);
    chk("R7 hardware reset clears lock and mask", 2'd0, 2'd0, 3'd5);

    cmd(2'd0, 16'h0081);
    pulse(1'b0, 1'b1, 1'b1, 2'd0, 16'h0030);
    chk("R11 software reset drops mode command", 2'd0, 2'd3, 3'd5);
    cmd(2'd2, 16'h0001);
    pulse(1'b0, 1'b1, 1'b1, 2'd1, 16'hFF4F);
    chk("R11 software reset drops configure", 2'd1, 2'd0, 3'd5);
    pulse(1'b1, 1'b1, 1'b0, 2'd3, 16'h0000);
    chk("R11 hardware beats software reset", 2'd0, 2'd0, 3'd5);

    #10;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule